// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial EEPROM. The host places a request on a valid/ready port with a start word address, a word count and a byte-swap flag. For each word, the block selects the device and shifts out an 11-bit read command. The command is the 6-bit word address combined with a 3-bit read opcode. The block then clocks in 16 data bits and deselects the device. Each finished word goes out on a valid/ready stream, with its two bytes exchanged if the flag was set. A one-cycle done pulse follows the last word of the request.

The serial clock runs from a parameterized divider: each high phase and each low phase lasts DIV system clocks. A word is held on the output until the consumer accepts it. While a word is waiting, the serial lines stay idle and the next word is not started, so back-pressure stalls the EEPROM sequence rather than dropping data. The request port accepts a new request only when the block is idle.

Top module: `ee_word_reader`

## Requirements
- R1: After reset, ee_cs, ee_sk, ee_di, out_valid and done are low and req_ready is high.
- R2: Each word is fetched with exactly 11 command bits sent MSB first. Bits 10:8 are 110, bits 7:6 are 00 and bits 5:0 are the word address. ee_di never changes while ee_sk is high.
- R3: ee_cs rises with ee_sk and ee_di low. It stays high with ee_sk low for 2*DIV clocks before the first rising edge of ee_sk, and it frames exactly 27 rising edges (11 command, 16 data).
- R4: The 16 data bits are taken MSB first from ee_do, sampled at the end of each ee_sk high phase.
- R5: Every ee_sk high phase lasts DIV clocks, and every ee_sk low phase between two clock pulses of a frame lasts DIV clocks. ee_sk is never high while ee_cs is low.
- R6: Between words, and while a finished word waits on the output, ee_cs, ee_sk and ee_di are all low.
- R7: A request reads count words from consecutive addresses starting at req_addr. The address wraps from 63 to 0.
- R8: If req_swap was high when the request was accepted, each output word has its upper and lower bytes exchanged. Otherwise the word is output as read.
- R9: Once out_valid is high, it stays high and out_data stays unchanged until out_ready is high. No further EEPROM access starts before then.
- R10: done is a single-cycle pulse one clock after the last word is accepted. A request with count 0 raises done one clock after acceptance, with no EEPROM activity.
- R11: req_ready is high only while the block is idle, and never while ee_cs or out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when req_valid is also high |
| req_addr | input | 6 | First word address |
| req_count | input | 7 | Number of words to read |
| req_swap | input | 1 | Exchange the bytes of each output word |
| out_valid | output | 1 | out_data holds a finished word |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Word read from the EEPROM |
| done | output | 1 | One-cycle pulse after the last word of a request |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach is a stall in the middle of a multi-word request. A finished word must sit on the output for many cycles while the serial bus stays quiet, and the next command must then resume at the right address. The bench reaches it by holding out_ready low from the request onward. It watches the first word and the idle bus for tens of cycles, then releases the stream and expects the rest of the sequence. A behavioural EEPROM model in the bench decodes every command frame and returns computed contents. A second request starts near the top of the address space, so the wrap to address 0 is exercised while out_ready toggles every cycle.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SEL,
    S_CMD_LO,
    S_CMD_HI,
    S_DAT_LO,
    S_DAT_HI,
    S_DESEL,
    S_PUSH,
    S_DONE
  } ee_state_e;

  localparam int unsigned OPW = 3;
  localparam logic [OPW-1:0] READ_OP = 3'b110;

endpackage

// File: rtl/ee_rd_div.sv
module ee_rd_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned DCW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DCW-1:0] cnt_q;

  assign tick = run && (cnt_q == DCW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ee_rd_piso.sv
module ee_rd_piso #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  assign msb = sr_q[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= load_val;
    end else if (shift) begin
      sr_q <= {sr_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ee_rd_sipo.sv
module ee_rd_sipo #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (shift) begin
      q <= {q[W-2:0], din};
    end
  end
endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int unsigned DIV   = 4,
  parameter int unsigned AW    = 6,
  parameter int unsigned CW    = 7,
  parameter int unsigned DW    = 16,
  parameter int unsigned CMD_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          req_swap,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          done,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do
);
  localparam int unsigned PADW = CMD_W - OPW - AW;
  localparam int unsigned MAXB = (DW > CMD_W) ? DW : CMD_W;
  localparam int unsigned BCW  = $clog2(MAXB);
  localparam int unsigned HW   = DW / 2;

  ee_state_e       state_q;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   left_q;
  logic            swap_q;
  logic [BCW-1:0]  bit_q;
  logic            run;
  logic            tick;
  logic            cmd_msb;
  logic [DW-1:0]   word;
  logic [CMD_W-1:0] cmd_word;

  // serial phases are timed by the divider
  assign run = (state_q == S_SEL)    || (state_q == S_CMD_LO) ||
               (state_q == S_CMD_HI) || (state_q == S_DAT_LO) ||
               (state_q == S_DAT_HI) || (state_q == S_DESEL);

  generate
    if (PADW > 0) begin : g_pad
      assign cmd_word = {READ_OP, {PADW{1'b0}}, addr_q};
    end else begin : g_nopad
      assign cmd_word = {READ_OP, addr_q};
    end
  endgenerate

  ee_rd_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  ee_rd_piso #(.W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state_q == S_SEL),
    .load_val (cmd_word),
    .shift    ((state_q == S_CMD_HI) && tick),
    .msb      (cmd_msb)
  );

  ee_rd_sipo #(.W(DW)) u_dat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == S_SEL),
    .shift ((state_q == S_DAT_HI) && tick),
    .din   (ee_do),
    .q     (word)
  );

  // serial pins decoded from the phase state
  assign ee_cs = (state_q == S_SEL)    || (state_q == S_CMD_LO) ||
                 (state_q == S_CMD_HI) || (state_q == S_DAT_LO) ||
                 (state_q == S_DAT_HI);
  assign ee_sk = (state_q == S_CMD_HI) || (state_q == S_DAT_HI);
  assign ee_di = ((state_q == S_CMD_LO) || (state_q == S_CMD_HI)) && cmd_msb;

  assign req_ready = (state_q == S_IDLE);
  assign out_valid = (state_q == S_PUSH);
  assign done      = (state_q == S_DONE);
  assign out_data  = swap_q ? {word[HW-1:0], word[DW-1:HW]} : word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      swap_q  <= 1'b0;
      bit_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            left_q  <= req_count;
            swap_q  <= req_swap;
            state_q <= (req_count == '0) ? S_DONE : S_SEL;
          end
        end
        S_SEL: begin
          bit_q <= '0;
          if (tick) state_q <= S_CMD_LO;
        end
        S_CMD_LO: begin
          if (tick) state_q <= S_CMD_HI;
        end
        S_CMD_HI: begin
          if (tick) begin
            if (bit_q == BCW'(CMD_W - 1)) begin
              bit_q   <= '0;
              state_q <= S_DAT_LO;
            end else begin
              bit_q   <= bit_q + 1'b1;
              state_q <= S_CMD_LO;
            end
          end
        end
        S_DAT_LO: begin
          if (tick) state_q <= S_DAT_HI;
        end
        S_DAT_HI: begin
          if (tick) begin
            if (bit_q == BCW'(DW - 1)) begin
              state_q <= S_DESEL;
            end else begin
              bit_q   <= bit_q + 1'b1;
              state_q <= S_DAT_LO;
            end
          end
        end
        S_DESEL: begin
          if (tick) state_q <= S_PUSH;
        end
        S_PUSH: begin
          if (out_ready) begin
            addr_q  <= addr_q + 1'b1;
            left_q  <= left_q - 1'b1;
            state_q <= (left_q == CW'(1)) ? S_DONE : S_SEL;
          end
        end
        S_DONE: begin
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ee_word_reader_chk.sv
module ee_word_reader_chk #(
  parameter int unsigned DIV = 4,
  parameter int unsigned DW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          done,
  input logic          ee_cs,
  input logic          ee_sk,
  input logic          ee_di
);
  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt_q <= '0;
    else if (ee_sk) hi_cnt_q <= hi_cnt_q + 1'b1;
    else hi_cnt_q <= '0;
  end

  // R2
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> $stable(ee_di));

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (!ee_sk && !ee_di));

  // R5
  sk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R5
  sk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> (hi_cnt_q == 16'(DIV)));

  // R6
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!ee_cs && !ee_sk && !ee_di));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !ee_cs));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ee_cs && !out_valid));
endmodule

bind ee_word_reader ee_word_reader_chk #(.DIV(DIV), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_di     (ee_di)
);

// File: tb/test_ee_word_reader.sv
`timescale 1ns/1ps
module test_ee_word_reader;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_addr = '0;
  logic [6:0]  req_count = '0;
  logic        req_swap = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        done;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;  // 0 always ready, 1 toggling, 2 held low

  logic [15:0] exp_q[$];
  logic [5:0]  addr_q[$];

  always #4 clk = ~clk;

  ee_word_reader #(.DIV(DIV)) i_ee_word_reader (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .req_swap(req_swap),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic logic [15:0] rom(input logic [5:0] a);
    return (16'(a) * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // EEPROM model
  int          mbits = 0;
  logic [10:0] mcmd = '0;
  logic [15:0] mword = '0;

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (mbits < 11) mcmd = {mcmd[9:0], ee_di};
      mbits++;
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs && mbits >= 11 && mbits <= 26) begin
      if (mbits == 11) mword = rom(mcmd[5:0]);
      ee_do <= mword[15 - (mbits - 11)];
    end
  end

  always @(negedge ee_cs) begin
    // R3 frame length
    chk(mbits == 27, "R3 clock edges per frame", mbits, 27);
    // R2 opcode and pad bits
    chk(mcmd[10:6] == 5'b11000, "R2 command upper bits", mcmd[10:6], 5'b11000);
    if (addr_q.size() == 0) begin
      chk(1'b0, "R7 unexpected frame", mcmd[5:0], 0);
    end else begin
      logic [5:0] ea;
      ea = addr_q.pop_front();
      chk(mcmd[5:0] == ea, "R7 word address", mcmd[5:0], ea);
    end
    mbits = 0;
    mcmd  = '0;
    ee_do <= 1'b0;
  end

  // ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R8 unexpected word", out_data, 0);
      end else begin
        logic [15:0] ew;
        ew = exp_q.pop_front();
        chk(out_data == ew, "R4/R8 word value", out_data, ew);
      end
    end
  end

  // serial clock phase timing monitor
  int   run_len = 0;
  bit   first_rise = 1'b1;
  logic prev_sk = 1'b0;
  always @(negedge clk) begin
    if (!ee_cs) begin
      run_len = 0;
      first_rise = 1'b1;
    end else if (ee_sk != prev_sk) begin
      if (ee_sk) begin
        if (first_rise) chk(run_len == 2*DIV, "R3 select lead time", run_len, 2*DIV);
        else chk(run_len == DIV, "R5 low phase", run_len, DIV);
        first_rise = 1'b0;
      end else begin
        chk(run_len == DIV, "R5 high phase", run_len, DIV);
      end
      run_len = 1;
    end else begin
      run_len++;
    end
    prev_sk = ee_sk;
  end

  task automatic send_req(input logic [5:0] a, input logic [6:0] n, input bit sw);
    for (int i = 0; i < n; i++) begin
      logic [5:0] wa;
      logic [15:0] w;
      wa = a + 6'(i);
      w = rom(wa);
      addr_q.push_back(wa);
      exp_q.push_back(sw ? {w[7:0], w[15:8]} : w);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b1;
    req_addr  = a;
    req_count = n;
    req_swap  = sw;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 20000);
    chk(done == 1'b1, "R10 done seen", done, 1);
    chk(exp_q.size() == 0, "R10 all words before done", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ee_cs && !ee_sk && !ee_di, "R1 serial lines idle", {ee_cs, ee_sk, ee_di}, 0);
    chk(!out_valid && !done, "R1 outputs idle", {out_valid, done}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // single word, no swap; R11 busy check during frame
    rdy_mode = 0;
    send_req(6'd5, 7'd1, 1'b0);
    do @(negedge clk); while (!ee_cs);
    chk(!req_ready, "R11 not ready while busy", req_ready, 0);
    wait_done();

    // several words with swap (R8)
    send_req(6'd10, 7'd3, 1'b1);
    wait_done();

    // wrap through address 63 with toggling ready (R7)
    rdy_mode = 1;
    send_req(6'd62, 7'd4, 1'b0);
    wait_done();

    // held back-pressure (R9, R6)
    rdy_mode = 2;
    send_req(6'd33, 7'd2, 1'b1);
    do @(negedge clk); while (!out_valid);
    begin
      logic [15:0] held;
      held = out_data;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        chk(out_valid && out_data == held, "R9 word held under stall", out_data, held);
        chk(!ee_cs && !ee_sk && !ee_di, "R6 bus quiet while word waits", {ee_cs, ee_sk, ee_di}, 0);
      end
    end
    rdy_mode = 0;
    wait_done();

    // zero count (R10)
    begin
      bit saw_cs = 1'b0;
      @(posedge clk);
      #1;
      req_valid = 1'b1;
      req_addr  = 6'd7;
      req_count = 7'd0;
      req_swap  = 1'b0;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk(done == 1'b1, "R10 zero count done", done, 1);
      saw_cs = saw_cs | ee_cs;
      @(negedge clk);
      chk(done == 1'b0, "R10 zero count single pulse", done, 0);
      saw_cs = saw_cs | ee_cs;
      chk(!saw_cs, "R10 zero count no bus access", saw_cs, 0);
    end

    chk(addr_q.size() == 0, "R7 all frames seen", addr_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule